// File: doc/BRIEF.md
# Dual-Path Double-Buffered Configuration Port

This block is the write path into a device's configuration register file. Bytes arrive over one of two routes. The first is a two-wire serial slave with an open-drain data output. The second is a byte-wide parallel port that writes one register per strobe. A mode pin picks the active route, and the other route is ignored.

Every configuration register has a working copy beside it, and the device logic reads only the working copies. A level-sensitive load control decides when staged values reach them. While load is high, writes collect in the configuration registers and the working copies hold their values. When load returns low, every working copy takes its register's value on the same clock edge. While load stays low, each write reaches its working copy on the edge that writes the register.

The serial side takes a 7-bit slave address. The top six bits come from a port and the lowest bit from a tie-off input, so two instances can share one bus. In a serial write, the first data byte selects a register index, and each later byte writes the next index. A serial read returns configuration registers starting at the current index and continues until the master declines a byte.

Top module: `cfg_dual_port`

## Requirements
- R1: With modeSel low, the serial slave is active and parWrEn has no effect. With modeSel high, the parallel port is active and the slave never pulls sdaDriveLow.
- R2: In parallel mode, parWrEn high at a clock edge writes parData into configuration register parIdx on that edge.
- R3: While loadCtl is high, workOut does not change, whether the writes come from the parallel port or the serial port.
- R4: At every clock edge where loadCtl is low, every working byte takes its configuration register's value. A high-to-low change of loadCtl therefore updates all staged registers on one edge.
- R5: While loadCtl is low, a write shows up in workOut on the same edge that updates the configuration register.
- R6: A start condition (data falling while the serial clock is high) begins reception of an address byte and clears the bit count, even in the middle of a byte. A stop condition (data rising while the clock is high) returns the slave to idle with data released.
- R7: The first byte after a start is sent most significant bit first and holds a 7-bit address followed by a read/write bit in bit 0, where 1 means read. The slave pulls data low on the ninth clock only when the address equals {chipAddrHi, addrLsbTie}. Otherwise it stays released and ignores the bus until the next start.
- R8: In a write, the byte after the address is the register index. Each following byte writes that index, the index then increments, and every byte is acknowledged. Indexes at or beyond NUM_REGS are acknowledged but write nothing, and the index does not wrap to 0.
- R9: In a read, the slave sends the configuration register at the current index, most significant bit first. If the master acknowledges (data low on the ninth clock), the index increments and the next register follows. If it does not (data high), the slave releases data until the next start or stop.
- R10: addrLsbTie supplies bit 0 of the slave address, so changing it moves the slave between two adjacent addresses.
- R11: Register i appears in workOut bits [8i+7:8i]. Reset clears all configuration and working registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 = serial slave active, 1 = parallel port active |
| loadCtl | input | 1 | 1 = hold working copies, 0 = working copies follow the registers |
| chipAddrHi | input | 6 | Bits 6..1 of the slave address |
| addrLsbTie | input | 1 | Bit 0 of the slave address (tie-off) |
| scl | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaDriveLow | output | 1 | 1 = pull the open-drain data line low |
| parIdx | input | IDX_W | Parallel write register index |
| parData | input | 8 | Parallel write data byte |
| parWrEn | input | 1 | Parallel write strobe, one byte per cycle it is high |
| workOut | output | NUM_REGS*8 | Working copies, register i in bits [8i+7:8i] |

## Verification
The hardest situation to reach from the ports is a start condition that lands in the middle of a byte. The bench sends half an address byte, then raises data and the clock and drops data again. It then expects a clean acknowledge for the next full address and a register write from the bytes that follow. The read path is just as awkward, because the slave drives data during the read. The bench therefore combines the master's open-drain drive with sdaDriveLow into one bus value. It issues a repeated start after setting the index, acknowledges the first byte and withholds the acknowledge on the second. It then checks that the slave has let go of the line.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int BYTE_W    = 8;
  localparam int IDX_MAX_W = 8;

  // Strobe from control to datapath: one byte write per cycle
  typedef struct packed {
    logic                 wrEn;
    logic [IDX_MAX_W-1:0] idx;
    logic [BYTE_W-1:0]    data;
  } cfgWrStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_LOAD, S_WAIT
  } serState_t;

  typedef enum logic [1:0] {B_ADDR, B_IDX, B_DATA} byteKind_t;
endpackage

// File: rtl/cfg_port_sync.sv
module cfg_port_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeSel,
  input  logic [6:0]           chipAddr,
  input  logic                 scl,
  input  logic                 sdaIn,
  output logic                 sdaDriveLow,
  input  logic [IDX_W-1:0]     parIdx,
  input  logic [BYTE_W-1:0]    parData,
  input  logic                 parWrEn,
  input  logic [BYTE_W-1:0]    rdData,
  output logic [IDX_MAX_W-1:0] rdIdx,
  output cfgWrStrobe_t         wrStrobe
);
  logic [1:0] busSync;
  logic       sclS, sdaS, sclQ, sdaQ;
  logic       sclRise, sclFall, startDet, stopDet;

  cfg_port_sync #(.WIDTH(2), .RST_VAL(2'b11)) uSync (
    .clk (clk), .rstN(rstN), .din({scl, sdaIn}), .dout(busSync)
  );
  assign sclS = busSync[1];
  assign sdaS = busSync[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  serState_t           state;
  byteKind_t           kind;
  logic [3:0]          bitCnt;
  logic [BYTE_W-1:0]   shiftIn, txShift;
  logic [IDX_MAX_W-1:0] idxReg;
  logic                toTx, mAck, sdaLow;
  cfgWrStrobe_t        serWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kind    <= B_ADDR;
      bitCnt  <= '0;
      shiftIn <= '0;
      txShift <= '0;
      idxReg  <= '0;
      toTx    <= 1'b0;
      mAck    <= 1'b0;
      sdaLow  <= 1'b0;
      serWr   <= '0;
    end else begin
      serWr.wrEn <= 1'b0;
      if (modeSel) begin
        state  <= S_IDLE;
        sdaLow <= 1'b0;
      end else if (startDet) begin
        state  <= S_RX;
        kind   <= B_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        state  <= S_IDLE;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftIn <= {shiftIn[BYTE_W-2:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              case (kind)
                B_ADDR: begin
                  if (shiftIn[7:1] == chipAddr) begin
                    sdaLow <= 1'b1;
                    toTx   <= shiftIn[0];
                    kind   <= B_IDX;
                    state  <= S_ACK;
                  end else begin
                    state <= S_WAIT;
                  end
                end
                B_IDX: begin
                  idxReg <= shiftIn;
                  sdaLow <= 1'b1;
                  toTx   <= 1'b0;
                  kind   <= B_DATA;
                  state  <= S_ACK;
                end
                default: begin
                  serWr.wrEn <= 1'b1;
                  serWr.idx  <= idxReg;
                  serWr.data <= shiftIn;
                  idxReg     <= idxReg + 1'b1;
                  sdaLow     <= 1'b1;
                  toTx       <= 1'b0;
                  state      <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (sclFall) begin
              if (toTx) begin
                state <= S_LOAD;
              end else begin
                sdaLow <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_LOAD: begin
            txShift <= rdData;
            sdaLow  <= ~rdData[7];
            bitCnt  <= '0;
            state   <= S_TX;
          end
          S_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaLow <= 1'b0;
                bitCnt <= '0;
                state  <= S_TXACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaLow  <= ~txShift[BYTE_W-2];
                bitCnt  <= bitCnt + 4'd1;
              end
            end
          end
          S_TXACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                idxReg <= idxReg + 1'b1;
                state  <= S_LOAD;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (modeSel) begin
      wrStrobe.wrEn = parWrEn;
      wrStrobe.idx  = IDX_MAX_W'(parIdx);
      wrStrobe.data = parData;
    end else begin
      wrStrobe = serWr;
    end
  end

  assign rdIdx       = idxReg;
  assign sdaDriveLow = sdaLow;
endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadCtl,
  input  cfgWrStrobe_t               wrStrobe,
  input  logic [IDX_MAX_W-1:0]       rdIdx,
  output logic [BYTE_W-1:0]          rdData,
  output logic [NUM_REGS*BYTE_W-1:0] cfgFlat,
  output logic [NUM_REGS*BYTE_W-1:0] workFlat
);
  logic [BYTE_W-1:0] cfgReg  [NUM_REGS];
  logic [BYTE_W-1:0] workReg [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic hit;
    assign hit = wrStrobe.wrEn && (wrStrobe.idx == IDX_MAX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg[g]  <= '0;
        workReg[g] <= '0;
      end else begin
        if (hit) cfgReg[g] <= wrStrobe.data;
        // Low load: working copy follows, with the same-edge write bypassed in
        if (!loadCtl) workReg[g] <= hit ? wrStrobe.data : cfgReg[g];
      end
    end

    assign cfgFlat[g*BYTE_W +: BYTE_W]  = cfgReg[g];
    assign workFlat[g*BYTE_W +: BYTE_W] = workReg[g];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdIdx == IDX_MAX_W'(i)) rdData = cfgReg[i];
    end
  end
endmodule

// File: rtl/cfg_dual_port.sv
module cfg_dual_port
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modeSel,
  input  logic                       loadCtl,
  input  logic [5:0]                 chipAddrHi,
  input  logic                       addrLsbTie,
  input  logic                       scl,
  input  logic                       sdaIn,
  output logic                       sdaDriveLow,
  input  logic [IDX_W-1:0]           parIdx,
  input  logic [7:0]                 parData,
  input  logic                       parWrEn,
  output logic [NUM_REGS*8-1:0]      workOut
);
  cfgWrStrobe_t                wrStrobe;
  logic [IDX_MAX_W-1:0]        rdIdx;
  logic [BYTE_W-1:0]           rdData;
  logic [NUM_REGS*BYTE_W-1:0]  cfgFlat;

  cfg_port_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .chipAddr   ({chipAddrHi, addrLsbTie}),
    .scl        (scl),
    .sdaIn      (sdaIn),
    .sdaDriveLow(sdaDriveLow),
    .parIdx     (parIdx),
    .parData    (parData),
    .parWrEn    (parWrEn),
    .rdData     (rdData),
    .rdIdx      (rdIdx),
    .wrStrobe   (wrStrobe)
  );

  cfg_port_dp #(.NUM_REGS(NUM_REGS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .loadCtl (loadCtl),
    .wrStrobe(wrStrobe),
    .rdIdx   (rdIdx),
    .rdData  (rdData),
    .cfgFlat (cfgFlat),
    .workFlat(workOut)
  );
endmodule

// File: rtl/cfg_dual_port_chk.sv
module cfg_dual_port_chk #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  modeSel,
  input logic                  loadCtl,
  input logic                  parWrEn,
  input logic [IDX_W-1:0]      parIdx,
  input logic [7:0]            parData,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] cfgFlat,
  input logic [NUM_REGS*8-1:0] workOut
);
  logic             lastVld;
  logic [IDX_W-1:0] lastIdx;
  logic [7:0]       lastData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastVld  <= 1'b0;
      lastIdx  <= '0;
      lastData <= '0;
    end else begin
      lastVld  <= modeSel && parWrEn && (int'(parIdx) < NUM_REGS);
      lastIdx  <= parIdx;
      lastData <= parData;
    end
  end

  // R1: parallel mode keeps the serial data line released
  assert_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    modeSel |=> !sdaDriveLow);

  // R2: a parallel write lands in the addressed register
  assert_parwr_R2: assert property (@(posedge clk) disable iff (!rstN)
    lastVld |-> cfgFlat[int'(lastIdx)*8 +: 8] == lastData);

  // R3: high load freezes the working copies
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadCtl |=> $stable(workOut));

  // R5: low load makes the working copies equal the registers after each edge
  assert_transp_R5: assert property (@(posedge clk) disable iff (!rstN)
    !loadCtl |=> workOut == cfgFlat);
endmodule

bind cfg_dual_port cfg_dual_port_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .loadCtl    (loadCtl),
  .parWrEn    (parWrEn),
  .parIdx     (parIdx),
  .parData    (parData),
  .sdaDriveLow(sdaDriveLow),
  .cfgFlat    (cfgFlat),
  .workOut    (workOut)
);

// File: tb/tb_cfg_dual_port.sv
module tb_cfg_dual_port;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = 3;
  localparam int Q        = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b1, loadCtl = 1'b0, addrLsbTie = 1'b1;
  logic [5:0] chipAddrHi = 6'h2A;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaDriveLow, sdaLine;
  logic [IDX_W-1:0] parIdx = '0;
  logic [7:0] parData = '0;
  logic parWrEn = 1'b0;
  logic [NUM_REGS*8-1:0] workOut;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  cfg_dual_port #(.NUM_REGS(NUM_REGS)) dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .loadCtl(loadCtl),
    .chipAddrHi(chipAddrHi), .addrLsbTie(addrLsbTie),
    .scl(sclM), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .parIdx(parIdx), .parData(parData), .parWrEn(parWrEn), .workOut(workOut)
  );

  // {load, idx, data, checked idx, expected working byte}
  localparam logic [27:0] VEC [5] = '{
    28'h0_0_11_0_11,
    28'h1_1_22_1_00,
    28'h1_0_33_0_11,
    28'h1_7_77_7_00,
    28'h1_2_44_2_00
  };

  function automatic logic [7:0] wk(int i);
    return workOut[i*8 +: 8];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q); sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sclM = 1'b0; sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q); sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic busBit(logic b);
    sdaM = b; waitQ(Q); sclM = 1'b1; waitQ(Q); sclM = 1'b0; waitQ(Q);
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) busBit(b[i]);
    sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(Q/2);
    ack = sdaLine; waitQ(Q/2); sclM = 1'b0; waitQ(Q);
  endtask

  task automatic readByte(logic ackBit, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q); sclM = 1'b1; waitQ(Q/2); d[i] = sdaLine; waitQ(Q/2); sclM = 1'b0;
    end
    sdaM = ackBit; waitQ(Q); sclM = 1'b1; waitQ(Q); sclM = 1'b0; waitQ(Q);
    sdaM = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset work0", wk(0), 8'h00);
    chk("R11 reset work7", wk(7), 8'h00);

    // Parallel vector table: R2 writes, R5 transparency, R3 hold
    for (int k = 0; k < 5; k++) begin
      logic [27:0] v;
      v = VEC[k];
      @(negedge clk);
      loadCtl = v[24]; parIdx = v[22:20]; parData = v[19:12]; parWrEn = 1'b1;
      @(negedge clk);
      parWrEn = 1'b0;
      chk($sformatf("R2/R3/R5 vector %0d", k), wk(int'(v[10:8])), v[7:0]);
    end

    // R4: all staged bytes arrive on one edge
    loadCtl = 1'b0;
    @(negedge clk);
    chk("R4 work0", wk(0), 8'h33);
    chk("R4 work1", wk(1), 8'h22);
    chk("R4 work2", wk(2), 8'h44);
    chk("R4 work7", wk(7), 8'h77);

    // R1: parallel strobe ignored in serial mode
    modeSel = 1'b0; parIdx = 3'd5; parData = 8'h99; parWrEn = 1'b1;
    @(negedge clk); parWrEn = 1'b0; @(negedge clk);
    chk("R1 parallel ignored", wk(5), 8'h00);

    // R1: serial slave silent in parallel mode
    modeSel = 1'b1;
    busStart(); sendByte(8'hAA, ack); busStop();
    chk("R1 no ack in parallel mode", {7'b0, ack}, 8'h01);
    modeSel = 1'b0; waitQ(4);

    // R7/R8: address 0x55 write, index 2, two bytes
    busStart();
    sendByte(8'hAA, ack); chk("R7 address ack", {7'b0, ack}, 8'h00);
    sendByte(8'h02, ack); chk("R8 index ack", {7'b0, ack}, 8'h00);
    sendByte(8'hA5, ack); chk("R8 data ack", {7'b0, ack}, 8'h00);
    sendByte(8'h5A, ack);
    busStop();
    @(negedge clk);
    chk("R6 released after stop", {7'b0, sdaDriveLow}, 8'h00);
    chk("R8 work2", wk(2), 8'hA5);
    chk("R8 work3", wk(3), 8'h5A);

    // R10: tie-off moves the address
    addrLsbTie = 1'b0;
    busStart(); sendByte(8'hAA, ack); busStop();
    chk("R10 old address rejected", {7'b0, ack}, 8'h01);
    busStart(); sendByte(8'hA8, ack); busStop();
    chk("R10 new address acked", {7'b0, ack}, 8'h00);
    addrLsbTie = 1'b1;

    // R7: mismatched address, following bytes ignored
    busStart();
    sendByte(8'hA8, ack); chk("R7 mismatch nack", {7'b0, ack}, 8'h01);
    sendByte(8'h04, ack); sendByte(8'hEE, ack);
    busStop();
    @(negedge clk);
    chk("R7 mismatch no write", wk(4), 8'h00);

    // R8: increment past the last register writes nothing and does not wrap
    busStart();
    sendByte(8'hAA, ack); sendByte(8'h07, ack);
    sendByte(8'h70, ack); sendByte(8'h80, ack);
    chk("R8 out-of-range byte acked", {7'b0, ack}, 8'h00);
    busStop();
    @(negedge clk);
    chk("R8 work7", wk(7), 8'h70);
    chk("R8 no wrap work0", wk(0), 8'h33);

    // R9: read from index 2, ack then nack
    busStart();
    sendByte(8'hAA, ack); sendByte(8'h02, ack);
    busStart();
    sendByte(8'hAB, ack); chk("R9 read address ack", {7'b0, ack}, 8'h00);
    readByte(1'b0, rd); chk("R9 first read byte", rd, 8'hA5);
    readByte(1'b1, rd); chk("R9 second read byte", rd, 8'h5A);
    waitQ(Q);
    chk("R9 released after nack", {7'b0, sdaDriveLow}, 8'h00);
    busStop();

    // R3/R4: serial write held by high load, then released
    @(negedge clk) loadCtl = 1'b1;
    busStart();
    sendByte(8'hAA, ack); sendByte(8'h06, ack); sendByte(8'h66, ack);
    busStop();
    @(negedge clk);
    chk("R3 serial write held", wk(6), 8'h00);
    loadCtl = 1'b0;
    @(negedge clk);
    chk("R4 serial write released", wk(6), 8'h66);

    // R6: start in mid-byte restarts address reception
    busStart();
    busBit(1'b1); busBit(1'b0); busBit(1'b1); busBit(1'b0);
    busStart();
    sendByte(8'hAA, ack); chk("R6 ack after restart", {7'b0, ack}, 8'h00);
    sendByte(8'h01, ack); sendByte(8'h5C, ack);
    busStop();
    @(negedge clk);
    chk("R6 write after restart", wk(1), 8'h5C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule